// File: doc/BRIEF.md
# Shared Global Comparator Timer

This block is a 64-bit free-running up-counter shared by a cluster of processor cores. Each core has a private comparator, a private auto-increment amount and private control bits, all behind one small word-addressed register port. A core-select input chooses which core's bank a register access reaches. The counter and each comparator are accessed as two 32-bit words.

A core's status flag goes up when its comparator is enabled and the shared count has reached or passed that core's comparator. The flag drives that core's interrupt line when the core's interrupt enable is set. With auto-increment on, the comparator advances by the core's increment on the same clock edge that raises the flag. A periodic tick then needs no software rewrite of the comparator. Counting is paced by a single tick-enable input, which stands in for an external prescaler.

Software reads a coherent 64-bit count by reading the high word, then the low word, then the high word again. If the two high reads differ, a carry happened in between. The counter words can be written only while the timer is stopped.

Top module: `gct_global_timer`

## Requirements
- R1: After reset the counter, every comparator, increment, control field and status flag is zero, and all interrupt lines are low.
- R2: The counter adds one on each clock edge at which the shared run bit (control bit 0, one copy common to all cores) and `tick_en` are both high. Otherwise it holds its value.
- R3: Word offsets on `reg_addr` are: 0 count low, 1 count high, 2 control, 3 status, 4 comparator low, 5 comparator high, 6 increment. Offset 7 reads as zero.
- R4: A carry out of the low count word enters the high word on the same edge. A high, low, high read sequence therefore shows a changed high word exactly when the low word wrapped in between.
- R5: Writes to the count words take effect only while the run bit is clear. While it is set, they are ignored.
- R6: Comparator words, increment and control bits 3:1 (1 compare enable, 2 interrupt enable, 3 auto-increment) are held per core and reached through `core_sel`. A write to one core leaves every other core's state unchanged.
- R7: A core's status bit 0 sets on the clock edge after the count becomes greater than or equal to its comparator while compare enable is set. It stays set until cleared.
- R8: `irq[i]` is high exactly while core i's status flag and interrupt enable are both set. A core with compare enable but no interrupt enable shows the flag without raising its line.
- R9: With auto-increment set, the comparator grows by the increment on each edge at which the flag condition holds. A software comparator write in the same cycle wins.
- R10: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it. A match in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count pacing enable from the prescaler |
| core_sel | input | SEL_W | Core bank selected for the access |
| reg_addr | input | 3 | Word offset of the register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data, combinational from offset and core |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
The assertions assume several things about the inputs. `core_sel` selects an existing core. A comparator is not rewritten by software in a cycle when the check on auto-increment is meant to apply, so that property excludes those cycles. A counter write never coincides with a tick while the timer runs. The stimulus keeps to these assumptions in three ways. It drives one register access at a time on falling edges. It only loads the counter after stopping the timer. It steps `tick_en` by whole cycles, so the counts reached at each check are exact.

// File: rtl/gct_pkg.sv
package gct_pkg;
   localparam int OFS_W = 3;
   localparam logic [OFS_W-1:0] OFS_CNT_LO = 3'd0;
   localparam logic [OFS_W-1:0] OFS_CNT_HI = 3'd1;
   localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd2;
   localparam logic [OFS_W-1:0] OFS_STAT   = 3'd3;
   localparam logic [OFS_W-1:0] OFS_CMP_LO = 3'd4;
   localparam logic [OFS_W-1:0] OFS_CMP_HI = 3'd5;
   localparam logic [OFS_W-1:0] OFS_INC    = 3'd6;

   // control word bit positions
   localparam int CB_RUN  = 0;
   localparam int CB_CMP  = 1;
   localparam int CB_IRQ  = 2;
   localparam int CB_AUTO = 3;

   // per-core config field (control bits 3:1)
   typedef struct packed {
      logic auto_inc;
      logic irq_en;
      logic cmp_en;
   } core_cfg_t;
endpackage

// File: rtl/gct_counter.sv
module gct_counter
   import gct_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int CNT_W = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_ctrl,
   input  logic [WORD_W-1:0] wdata,
   output logic              run,
   output logic [CNT_W-1:0]  cnt
);
   logic run_q;
   logic [CNT_W-1:0] cnt_q;

   // shared run bit, written from any core's control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= 1'b0;
      else if (wr_ctrl) run_q <= wdata[CB_RUN];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run_q) begin
         if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
      end else begin
         if (wr_lo) cnt_q[WORD_W-1:0]     <= wdata;
         if (wr_hi) cnt_q[CNT_W-1:WORD_W] <= wdata;
      end
   end

   assign run = run_q;
   assign cnt = cnt_q;
endmodule

// File: rtl/gct_core_slot.sv
module gct_core_slot
   import gct_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int INC_W       = 32,
   parameter bit AUTO_INC_EN = 1'b1,
   localparam int CNT_W = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              we,
   input  logic [OFS_W-1:0]  addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [CNT_W-1:0]  cmp,
   output logic [INC_W-1:0]  inc,
   output core_cfg_t         cfg,
   output logic              flag,
   output logic              irq
);
   core_cfg_t cfg_q;
   logic [CNT_W-1:0] cmp_q;
   logic flag_q;
   logic hit;
   logic wr_cmp_lo, wr_cmp_hi;

   assign hit       = cfg_q.cmp_en && (cnt >= cmp_q);
   assign wr_cmp_lo = we && (addr == OFS_CMP_LO);
   assign wr_cmp_hi = we && (addr == OFS_CMP_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (we && addr == OFS_CTRL)
         cfg_q <= '{auto_inc: wdata[CB_AUTO], irq_en: wdata[CB_IRQ], cmp_en: wdata[CB_CMP]};
   end

   generate
      if (AUTO_INC_EN) begin : g_autoinc
         logic [INC_W-1:0] inc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     inc_q <= '0;
            else if (we && addr == OFS_INC) inc_q <= wdata[INC_W-1:0];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmp_q <= '0;
            end else if (wr_cmp_lo || wr_cmp_hi) begin
               if (wr_cmp_lo) cmp_q[WORD_W-1:0]     <= wdata;
               if (wr_cmp_hi) cmp_q[CNT_W-1:WORD_W] <= wdata;
            end else if (hit && cfg_q.auto_inc) begin
               cmp_q <= cmp_q + CNT_W'(inc_q);
            end
         end
         assign inc = inc_q;
      end else begin : g_fixed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmp_q <= '0;
            end else begin
               if (wr_cmp_lo) cmp_q[WORD_W-1:0]     <= wdata;
               if (wr_cmp_hi) cmp_q[CNT_W-1:WORD_W] <= wdata;
            end
         end
         assign inc = '0;
      end
   endgenerate

   // match sets the flag; a write of 1 clears it; a match wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flag_q <= 1'b0;
      else if (hit)                                flag_q <= 1'b1;
      else if (we && addr == OFS_STAT && wdata[0]) flag_q <= 1'b0;
   end

   assign cmp  = cmp_q;
   assign cfg  = cfg_q;
   assign flag = flag_q;
   assign irq  = flag_q && cfg_q.irq_en;
endmodule

// File: rtl/gct_read_mux.sv
module gct_read_mux
   import gct_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int WORD_W    = 32,
   parameter int INC_W     = 32,
   localparam int CNT_W = 2 * WORD_W,
   localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [OFS_W-1:0]                  addr,
   input  logic [SEL_W-1:0]                  sel,
   input  logic                              run,
   input  logic [CNT_W-1:0]                  cnt,
   input  logic [NUM_CORES-1:0][CNT_W-1:0]   cmp_a,
   input  logic [NUM_CORES-1:0][INC_W-1:0]   inc_a,
   input  core_cfg_t [NUM_CORES-1:0]         cfg_a,
   input  logic [NUM_CORES-1:0]              flag_a,
   output logic [WORD_W-1:0]                 rdata
);
   logic sel_ok;
   assign sel_ok = int'(sel) < NUM_CORES;

   always_comb begin
      rdata = '0;
      unique case (addr)
         OFS_CNT_LO: rdata = cnt[WORD_W-1:0];
         OFS_CNT_HI: rdata = cnt[CNT_W-1:WORD_W];
         OFS_CTRL: begin
            rdata[CB_RUN] = run;
            if (sel_ok) begin
               rdata[CB_CMP]  = cfg_a[sel].cmp_en;
               rdata[CB_IRQ]  = cfg_a[sel].irq_en;
               rdata[CB_AUTO] = cfg_a[sel].auto_inc;
            end
         end
         OFS_STAT:   if (sel_ok) rdata[0] = flag_a[sel];
         OFS_CMP_LO: if (sel_ok) rdata = cmp_a[sel][WORD_W-1:0];
         OFS_CMP_HI: if (sel_ok) rdata = cmp_a[sel][CNT_W-1:WORD_W];
         OFS_INC:    if (sel_ok) rdata = WORD_W'(inc_a[sel]);
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/gct_global_timer.sv
module gct_global_timer
   import gct_pkg::*;
#(
   parameter int NUM_CORES   = 2,
   parameter int WORD_W      = 32,
   parameter int INC_W       = 32,
   parameter bit AUTO_INC_EN = 1'b1,
   localparam int CNT_W = 2 * WORD_W,
   localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [SEL_W-1:0]  core_sel,
   input  logic [OFS_W-1:0]  reg_addr,
   input  logic              reg_we,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic [NUM_CORES-1:0] irq
);
   generate
      if (NUM_CORES < 1 || NUM_CORES > 64) begin : g_bad_cores
         $error("NUM_CORES must lie in 1..64");
      end
      if (WORD_W < 4) begin : g_bad_word
         $error("WORD_W must hold the four control bits");
      end
      if (INC_W < 1 || INC_W > WORD_W) begin : g_bad_inc
         $error("INC_W must lie in 1..WORD_W");
      end
   endgenerate

   logic run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NUM_CORES-1:0][CNT_W-1:0] cmp_a;
   logic [NUM_CORES-1:0][INC_W-1:0] inc_a;
   core_cfg_t [NUM_CORES-1:0] cfg_a;
   logic [NUM_CORES-1:0] flag_a;
   logic [NUM_CORES-1:0] core_we;

   gct_counter #(.WORD_W(WORD_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_lo   (reg_we && reg_addr == OFS_CNT_LO),
      .wr_hi   (reg_we && reg_addr == OFS_CNT_HI),
      .wr_ctrl (reg_we && reg_addr == OFS_CTRL),
      .wdata   (reg_wdata),
      .run     (run_q),
      .cnt     (cnt_q)
   );

   generate
      for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
         assign core_we[i] = reg_we && (int'(core_sel) == i);
         gct_core_slot #(
            .WORD_W      (WORD_W),
            .INC_W       (INC_W),
            .AUTO_INC_EN (AUTO_INC_EN)
         ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_q),
            .we    (core_we[i]),
            .addr  (reg_addr),
            .wdata (reg_wdata),
            .cmp   (cmp_a[i]),
            .inc   (inc_a[i]),
            .cfg   (cfg_a[i]),
            .flag  (flag_a[i]),
            .irq   (irq[i])
         );
      end
   endgenerate

   gct_read_mux #(
      .NUM_CORES (NUM_CORES),
      .WORD_W    (WORD_W),
      .INC_W     (INC_W)
   ) u_rd (
      .addr   (reg_addr),
      .sel    (core_sel),
      .run    (run_q),
      .cnt    (cnt_q),
      .cmp_a  (cmp_a),
      .inc_a  (inc_a),
      .cfg_a  (cfg_a),
      .flag_a (flag_a),
      .rdata  (reg_rdata)
   );
endmodule

// File: rtl/gct_checker.sv
module gct_checker
   import gct_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int WORD_W    = 32,
   parameter int INC_W     = 32,
   localparam int CNT_W = 2 * WORD_W,
   localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            tick_en,
   input logic                            run,
   input logic [CNT_W-1:0]                cnt,
   input logic                            reg_we,
   input logic [OFS_W-1:0]                reg_addr,
   input logic [SEL_W-1:0]                core_sel,
   input logic                            clr_bit,
   input logic [NUM_CORES-1:0][CNT_W-1:0] cmp_a,
   input logic [NUM_CORES-1:0][INC_W-1:0] inc_a,
   input core_cfg_t [NUM_CORES-1:0]       cfg_a,
   input logic [NUM_CORES-1:0]            flag_a
);
   logic cnt_wr;
   assign cnt_wr = reg_we && (reg_addr == OFS_CNT_LO || reg_addr == OFS_CNT_HI);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick_en |=> cnt == $past(cnt) + CNT_W'(1)); // R2

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en && !cnt_wr |=> $stable(cnt)); // R2

   AST_CNT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      run && !tick_en |=> $stable(cnt)); // R5

   AST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick_en && (&cnt[WORD_W-1:0])
      |=> cnt[CNT_W-1:WORD_W] == $past(cnt[CNT_W-1:WORD_W]) + WORD_W'(1)); // R4

   generate
      for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
         logic own_we, own_cmp_wr;
         assign own_we     = reg_we && (int'(core_sel) == i);
         assign own_cmp_wr = own_we && (reg_addr == OFS_CMP_LO || reg_addr == OFS_CMP_HI);

         AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_a[i].cmp_en && (cnt >= cmp_a[i]) |=> flag_a[i]); // R7

         AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_a[i]) |-> $past(cfg_a[i].cmp_en)); // R7

         AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_a[i].cmp_en && cfg_a[i].auto_inc && (cnt >= cmp_a[i]) && !own_cmp_wr
            |=> cmp_a[i] == $past(cmp_a[i]) + CNT_W'($past(inc_a[i]))); // R9

         AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            own_we && reg_addr == OFS_STAT && clr_bit
            && !(cfg_a[i].cmp_en && cnt >= cmp_a[i]) |=> !flag_a[i]); // R10

         AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
            !own_we && !(cfg_a[i].cmp_en && cfg_a[i].auto_inc) |=> $stable(cmp_a[i])); // R6
      end
   endgenerate
endmodule

bind gct_global_timer gct_checker #(
   .NUM_CORES (NUM_CORES),
   .WORD_W    (WORD_W),
   .INC_W     (INC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .run      (run_q),
   .cnt      (cnt_q),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .core_sel (core_sel),
   .clr_bit  (reg_wdata[0]),
   .cmp_a    (cmp_a),
   .inc_a    (inc_a),
   .cfg_a    (cfg_a),
   .flag_a   (flag_a)
);

// File: tb/gct_global_timer_test.sv
`timescale 1ns/1ps
module gct_global_timer_test;
   localparam int NC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic [0:0] core_sel = '0;
   logic [2:0] reg_addr = '0;
   logic reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NC-1:0] irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   gct_global_timer #(.NUM_CORES(NC)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .core_sel(core_sel),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int s, input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      core_sel = 1'(s); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int s, input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      core_sel = 1'(s); reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(0, 3'd0, v); check("R1 count low", v, 0);
      rd(0, 3'd1, v); check("R1 count high", v, 0);
      rd(0, 3'd2, v); check("R1 ctrl core0", v, 0);
      rd(1, 3'd3, v); check("R1 status core1", v, 0);
      rd(1, 3'd4, v); check("R1 cmp core1", v, 0);
      check("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_counter;
      logic [31:0] v, h1, lo, h2;
      wr(0, 3'd0, 32'hFFFF_FFFF);
      wr(0, 3'd1, 32'h0000_0003);
      rd(0, 3'd0, v); check("R3 count low word", v, 32'hFFFF_FFFF);
      rd(0, 3'd1, v); check("R3 count high word", v, 3);
      rd(0, 3'd7, v); check("R3 unused offset", v, 0);
      wr(0, 3'd2, 32'h1);                // run, tick_en low
      rd(0, 3'd1, h1);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;    // one tick
      rd(0, 3'd0, lo);
      rd(0, 3'd1, h2);
      check("R4 high moved between reads", h2, h1 + 1);
      check("R4 low wrapped", lo, 0);
      wr(0, 3'd0, 32'h0000_1234);        // ignored while running
      rd(0, 3'd0, v); check("R5 write ignored while running", v, 0);
      repeat (5) @(negedge clk);
      rd(0, 3'd0, v); check("R2 holds without tick", v, 0);
      @(negedge clk); tick_en = 1'b1;
      repeat (3) @(negedge clk);
      tick_en = 1'b0;
      rd(0, 3'd0, v); check("R2 three ticks", v, 3);
      wr(0, 3'd2, 32'h0);
      wr(0, 3'd0, 32'h0000_0042);
      rd(0, 3'd0, v); check("R5 write accepted when stopped", v, 32'h42);
   endtask

   task automatic t_match;
      logic [31:0] v;
      wr(0, 3'd0, 0);
      wr(0, 3'd1, 0);
      wr(0, 3'd4, 20);
      wr(0, 3'd5, 0);
      wr(1, 3'd4, 5);
      wr(1, 3'd2, 32'h2);                // core1: compare only
      rd(0, 3'd4, v); check("R6 core0 cmp kept", v, 20);
      tick_en = 1'b1;
      wr(0, 3'd2, 32'h7);                // run + compare + irq for core0
      repeat (20) @(negedge clk);
      #1 check("R7 no flag before match", 32'(irq[0]), 0);
      @(negedge clk);
      #1 check("R7 irq one edge after match", 32'(irq[0]), 1);
      rd(1, 3'd3, v); check("R8 core1 flag set", v, 1);
      check("R8 core1 line masked", 32'(irq[1]), 0);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      wr(0, 3'd2, 32'h4);                // stop, keep irq enable only
      tick_en = 1'b0;
      wr(0, 3'd3, 32'h1);
      rd(0, 3'd3, v); check("R10 w1c clears", v, 0);
      check("R10 line drops", 32'(irq[0]), 0);
      wr(1, 3'd3, 32'h0);
      rd(1, 3'd3, v); check("R10 write zero keeps", v, 1);
      wr(1, 3'd3, 32'h1);                // match still true: set wins
      rd(1, 3'd3, v); check("R10 match beats clear", v, 1);
   endtask

   task automatic t_autoinc;
      logic [31:0] v;
      wr(0, 3'd0, 0);
      wr(0, 3'd4, 10);
      wr(0, 3'd6, 8);
      rd(0, 3'd6, v); check("R3 increment word", v, 8);
      tick_en = 1'b1;
      wr(0, 3'd2, 32'hF);
      repeat (28) @(negedge clk);
      wr(0, 3'd2, 32'hE);
      tick_en = 1'b0;
      rd(0, 3'd0, v); check("R2 count after run", v, 30);
      rd(0, 3'd4, v); check("R9 comparator advanced", v, 34);
      rd(0, 3'd5, v); check("R9 comparator high", v, 0);
      check("R8 core0 line up", 32'(irq[0]), 1);
      rd(1, 3'd4, v); check("R6 core1 cmp untouched", v, 5);
      rd(0, 3'd2, v); check("R6 ctrl readback", v, 32'hE);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_counter();
      t_match();
      t_clear();
      t_autoinc();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule